// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block takes short command frames from a single-bit serial line and turns each valid frame into a three-bit word and a one-cycle strobe. The line carries one bit per clock cycle and changes only on the rising clock edge. It rests low. A frame opens with a high start bit, carries its data bits least significant first, and closes with two stop bits that must both be low.

The line first passes through a register clocked on the falling edge. The control state machine, clocked on the rising edge, reads only that re-sampled copy, so the line always has half a period to settle. Each data bit is written straight into its own holding register as it arrives, and the word stays there between frames. If both stop bits are low, the strobe rises for one cycle and the receiver returns to idle. It can accept a new start bit in the very next cycle. A high stop bit ends the frame at once, with no strobe.

Top module: `cmd_frame_rx`

## Requirements
- R1: The line is sampled only at falling clock edges. A high level that starts after a falling edge and ends before the next falling edge is ignored: it produces no strobe and no data write.
- R2: A frame is a start bit at 1, then data bits D0, D1, D2 in consecutive cycles, then two stop bits. In idle, line value 0 is ignored.
- R3: Data bit Dk is written to output dataOut[k] (bit 0 = D0, bit 2 = D2) in the cycle that bit is decoded.
- R4: frameValid is high for exactly one cycle, in the cycle after the second stop bit is decoded, and only when both stop bits are 0.
- R5: A stop bit decoded as 1 ends the frame at once, with no strobe. That same bit is not treated as a start bit, and the receiver is idle in the following cycle.
- R6: After a valid frame, the receiver is idle again. A start bit sent in the cycle right after the second stop bit begins a new frame, so frames may be sent back to back.
- R7: dataOut holds its value while idle and between frames. It changes only while data bits are being received, including the data bits of frames that are later rejected.
- R8: When rstN is low, the block is forced at once, without waiting for a clock edge, into idle with dataOut = 0 and frameValid = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The line is sampled on the falling edge and the state machine runs on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lineIn | input | 1 | Serial line, idle low, changes on the rising edge |
| dataOut | output | 3 | Holding registers for the last received data bits (bit k = Dk) |
| frameValid | output | 1 | One-cycle strobe for a frame whose two stop bits were both 0 |

## Verification
The bench uses the default parameters: three data bits and two stop bits. With these values, every data word can be combined with every stop-bit pattern in a single continuous stream of 32 frames. Valid frames run back to back or with short gaps. Rejected frames are followed by idle time, so the rejection path and the frame that a late high stop bit starts can both be predicted and checked.

// File: rtl/cmd_frame_rx_pkg.sv
package cmd_frame_rx_pkg;

  // Width of the bit index carried from control to datapath (up to 16 data bits).
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             dataWe;   // write the re-sampled bit into a holding register
    logic [IDX_W-1:0] dataIdx;  // which holding register to write
  } rx_ctrl_t;

endpackage

// File: rtl/cmd_frame_rx_dp.sv
module cmd_frame_rx_dp
  import cmd_frame_rx_pkg::*;
#(
  parameter int DATA_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineIn,
  input  rx_ctrl_t             ctrl,
  output logic                 lineSync,
  output logic [DATA_BITS-1:0] dataOut
);

  // Re-sample the line half a period after it changes.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) lineSync <= 1'b0;
    else       lineSync <= lineIn;
  end

  for (genvar gi = 0; gi < DATA_BITS; gi++) begin : g_hold
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bitQ <= 1'b0;
      else if (ctrl.dataWe && ctrl.dataIdx == IDX_W'(gi))
        bitQ <= lineSync;
    end
    assign dataOut[gi] = bitQ;
  end

  // Holding registers keep their contents whenever no data bit is being taken.
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.dataWe |=> $stable(dataOut));

endmodule

// File: rtl/cmd_frame_rx_ctl.sv
module cmd_frame_rx_ctl
  import cmd_frame_rx_pkg::*;
#(
  parameter int DATA_BITS = 3,
  parameter int STOP_BITS = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineSync,
  output rx_ctrl_t ctrl,
  output logic     frameValid
);

  localparam int MAXB  = (DATA_BITS > STOP_BITS) ? DATA_BITS : STOP_BITS;
  localparam int CNT_W = (MAXB > 1) ? $clog2(MAXB) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_STOP} rx_state_e;

  rx_state_e        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             validNext;

  always_comb begin
    stateNext    = state;
    cntNext      = cnt;
    validNext    = 1'b0;
    ctrl.dataWe  = 1'b0;
    ctrl.dataIdx = IDX_W'(cnt);
    unique case (state)
      ST_IDLE: begin
        cntNext = '0;
        if (lineSync) stateNext = ST_DATA;
      end
      ST_DATA: begin
        ctrl.dataWe = 1'b1;
        if (cnt == CNT_W'(DATA_BITS - 1)) begin
          stateNext = ST_STOP;
          cntNext   = '0;
        end else begin
          cntNext = cnt + CNT_W'(1);
        end
      end
      ST_STOP: begin
        if (lineSync) begin
          stateNext = ST_IDLE;
          cntNext   = '0;
        end else if (cnt == CNT_W'(STOP_BITS - 1)) begin
          stateNext = ST_IDLE;
          cntNext   = '0;
          validNext = 1'b1;
        end else begin
          cntNext = cnt + CNT_W'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      frameValid <= 1'b0;
    end else begin
      state      <= stateNext;
      cnt        <= cntNext;
      frameValid <= validNext;
    end
  end

  // A start bit seen in idle begins reception of D0.
  p_start_enter_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && lineSync) |=> (state == ST_DATA && cnt == '0));

  // The strobe never lasts more than one cycle.
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  // A high stop bit aborts the frame without a strobe.
  p_stop_abort_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && lineSync) |=> (state == ST_IDLE && !frameValid));

  // While the strobe is up, the receiver is already idle and ready.
  p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> state == ST_IDLE);

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cmd_frame_rx_pkg::*;
#(
  parameter int DATA_BITS = 3,
  parameter int STOP_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineIn,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 frameValid
);

  rx_ctrl_t ctrl;
  logic     lineSync;

  cmd_frame_rx_dp #(
    .DATA_BITS (DATA_BITS)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .ctrl     (ctrl),
    .lineSync (lineSync),
    .dataOut  (dataOut)
  );

  cmd_frame_rx_ctl #(
    .DATA_BITS (DATA_BITS),
    .STOP_BITS (STOP_BITS)
  ) i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .lineSync   (lineSync),
    .ctrl       (ctrl),
    .frameValid (frameValid)
  );

endmodule

// File: tb/test_cmd_frame_rx.sv
`timescale 1ns/1ps
module test_cmd_frame_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineIn = 1'b0;
  logic [2:0] dataOut;
  logic       frameValid;

  int checks = 0;
  int fails  = 0;

  // Stream tables: bit to drive, strobe expected after decoding it, data expected.
  logic       bits    [0:1023];
  logic       expV    [0:1023];
  logic       holdChk [0:1023];
  logic [2:0] expD    [0:1023];
  int         len = 0;
  logic [2:0] lastD = 3'd0;

  always #4 clk = ~clk;

  cmd_frame_rx i_cmd_frame_rx (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineIn),
    .dataOut    (dataOut),
    .frameValid (frameValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pushBit(input logic b);
    bits[len] = b;
    len++;
  endtask

  // s[0] = first stop bit, s[1] = second stop bit
  task automatic appendFrame(input logic [2:0] d, input logic [1:0] s, input int gap);
    int p;
    p = len;
    pushBit(1'b1);
    pushBit(d[0]); pushBit(d[1]); pushBit(d[2]);
    pushBit(s[0]); pushBit(s[1]);
    if (s == 2'b00) begin
      expV[p+5] = 1'b1;  // R4: strobe after the second stop bit
      expD[p+5] = d;
      lastD = d;
    end else if (s == 2'b11) begin
      // R5: the first stop bit aborts; the second is then a start of a frame of zeros
      expV[p+10] = 1'b1;
      expD[p+10] = 3'd0;
      lastD = 3'd0;
    end else begin
      lastD = d;
    end
    for (int g = 0; g < gap; g++) pushBit(1'b0);
    if (gap > 0) begin
      holdChk[len-1] = 1'b1;  // R7: data held through idle
      expD[len-1]    = lastD;
    end
  endtask

  task automatic runStream();
    for (int i = 0; i <= len; i++) begin
      @(posedge clk);
      #1 lineIn = (i < len) ? bits[i] : 1'b0;
      #1;
      if (i > 0) begin
        chk(expV[i-1] ? "R4 strobe" : "R4/R5 no strobe", 32'(frameValid), 32'(expV[i-1]));
        if (expV[i-1]) chk("R3/R6 data at strobe", 32'(dataOut), 32'(expD[i-1]));
        if (holdChk[i-1]) chk("R7 data held", 32'(dataOut), 32'(expD[i-1]));
      end
    end
  endtask

  initial begin : watchdog
    #(64'd200000 * 8);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      bits[i] = 1'b0; expV[i] = 1'b0; holdChk[i] = 1'b0; expD[i] = 3'd0;
    end

    // R8: state while and after reset
    repeat (3) @(posedge clk);
    #2 chk("R8 reset valid", 32'(frameValid), 32'd0);
    chk("R8 reset data", 32'(dataOut), 32'd0);
    @(posedge clk); #1 rstN = 1'b1;

    // Partial frame: start, D0=1, D1=1, then asynchronous reset
    @(posedge clk); #1 lineIn = 1'b1;
    @(posedge clk); #1 lineIn = 1'b1;
    @(posedge clk); #1 lineIn = 1'b1;
    @(posedge clk); #2 chk("R3 partial write D0 D1", 32'(dataOut), 32'd3);
    #1 rstN = 1'b0;
    #0.5 chk("R8 async clear data", 32'(dataOut), 32'd0);
    chk("R8 async valid low", 32'(frameValid), 32'd0);
    lineIn = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;

    // Exhaustive sweep R2..R7: every data word with every stop pattern
    for (int d = 0; d < 8; d++) begin
      for (int s = 0; s < 4; s++) begin
        if (s == 0) appendFrame(3'(d), 2'(s), (d % 2 == 1) ? 3 : 0);  // R6 back to back
        else        appendFrame(3'(d), 2'(s), 8);
      end
    end
    appendFrame(3'd7, 2'b00, 2);
    runStream();

    // R1: a high level between a falling edge and the next one is never seen
    @(negedge clk); #1 lineIn = 1'b1;
    @(posedge clk); #2.5 lineIn = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #2 chk("R1 short level ignored, no strobe", 32'(frameValid), 32'd0);
    end
    chk("R1 short level ignored, data kept", 32'(dataOut), 32'd7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule